// File: doc/BRIEF.md
# Interrupt Pending-State Distributor

This block keeps the per-source state of a bank of interrupt inputs: an enable bit, a pending latch, an active bit and a trigger mode. Each source is either edge-triggered or level-triggered. An edge source records a rising edge of its input in its pending latch. For a level source, the pending state that software sees and that the selector uses is the live input line ORed with the same latch, which only software sets. A single request output tells the processor that work is waiting.

The processor takes an interrupt by pulsing the acknowledge request. The block returns the lowest-numbered enabled source that is pending and not already active, clears that source's latch and marks it active. When no source qualifies, it returns the spurious code 1023. Writing the same ID to the end-of-interrupt port clears the active bit. The build parameter `LEGACY` selects an older enable behaviour. In that mode, enabling a level source whose line is high also sets its latch. In the default mode the enable write leaves the latch alone.

The acknowledge path is a two-state machine. In `ACK_IDLE`, an acknowledge request moves it to `ACK_DONE` (transition *grant*). In that same edge the ID is registered and the source state is updated. `ACK_DONE` asserts `ack_done` for exactly one cycle and always returns to `ACK_IDLE` (transition *release*). Requests that arrive while the machine is in `ACK_DONE` are ignored.

Top module: `irqd_top`

## Requirements
- R1: After reset, every enable, pending latch, active bit and trigger-mode bit is 0 (level mode), `irq_out` is 0 and `ack_done` is 0.
- R2: Register selects on `reg_addr`: 0 is set-enable and 1 is clear-enable, both writing 1s and both reading the enable vector. 2 is set-pending and 3 is clear-pending, both writing 1s and both reading the effective pending vector. 4 is the trigger-mode vector, read/write, where bit value 1 means edge. 5 reads the active vector. Any other value reads 0.
- R3: For a level source, effective pending is its input line OR its latch. A 1 written to set-pending keeps the latch set after the line falls, until an acknowledge of that source or a 1 written to clear-pending.
- R4: A 1 written to clear-pending clears the latch. A level source whose line is still high keeps reading as pending.
- R5: An edge source sets its latch on a rising edge of its input (line high now, low in the previous cycle). The latch stays set after the line falls, and a line that is held high does not set it again. Its effective pending is the latch alone.
- R6: With `LEGACY`=0, a set-enable write to a level source whose line is high does not set the latch, so the source stops pending when the line falls.
- R7: With `LEGACY`=1, a set-enable write to a level source whose line is high sets the latch, so the source stays pending after the line falls.
- R8: Set-enable writes OR 1s into the enable vector. Clear-enable writes remove them.
- R9: An acknowledge request accepted in `ACK_IDLE` gives `ack_done`=1 for one cycle, starting one cycle later. `ack_id` then holds the lowest-numbered source that is enabled, pending and not active. That source's latch is cleared and its active bit is set.
- R10: When no source is enabled, pending and not active, the acknowledge returns `ack_id` = 1023 and changes no state.
- R11: An end-of-interrupt whose ID matches a source clears that source's active bit. An ID that matches no active source has no effect. A level source whose line is still high is pending and requesting again in the next cycle.
- R12: `irq_out` is 1 exactly when at least one source is enabled, pending and not active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | NUM_SRC | Write data, one bit per source |
| reg_rdata | output | NUM_SRC | Read data for the selected register |
| src_line | input | NUM_SRC | Interrupt input lines |
| ack_req | input | 1 | Acknowledge request |
| ack_done | output | 1 | Acknowledge result valid (one cycle) |
| ack_id | output | ID_W | Acknowledged source ID or 1023 |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_id | input | ID_W | End-of-interrupt source ID |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench builds two copies with the default 32 sources and 10-bit IDs. Both copies are driven from the same inputs. One has `LEGACY`=0 and the other has `LEGACY`=1, so a single enable write with a level line high shows the two pending behaviours side by side. The vector table sets bits 4 to 7 to edge mode and keeps bits 0 to 3 in level mode. This brings edge and level latches, held lines and clear writes into the same sequence. Directed cases then cover the selection order, the spurious code, mismatched end-of-interrupt IDs and a level line that is still high at end-of-interrupt.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    typedef enum logic [2:0] {
        REG_SET_EN   = 3'd0,
        REG_CLR_EN   = 3'd1,
        REG_SET_PEND = 3'd2,
        REG_CLR_PEND = 3'd3,
        REG_TRIG     = 3'd4,
        REG_ACTIVE   = 3'd5
    } reg_sel_e;

    typedef enum logic {
        ACK_IDLE = 1'b0,
        ACK_DONE = 1'b1
    } ack_state_e;

    localparam int SPURIOUS_ID = 1023;

endpackage

// File: rtl/irqd_src_slice.sv
module irqd_src_slice #(
    parameter bit LEGACY = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic en_set,
    input  logic en_clr,
    input  logic pend_set,
    input  logic pend_clr,
    input  logic trig_wr,
    input  logic trig_val,
    input  logic take,
    input  logic eoi_hit,
    output logic enable,
    output logic edge_mode,
    output logic active,
    output logic pend_eff,
    output logic cand
);

    logic line_q;
    logic latch;
    logic rise;
    logic capture;

    assign rise    = edge_mode & line & ~line_q;
    assign capture = LEGACY & en_set & ~edge_mode & line;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q    <= 1'b0;
            latch     <= 1'b0;
            enable    <= 1'b0;
            edge_mode <= 1'b0;
            active    <= 1'b0;
        end else begin
            line_q <= line;
            latch  <= (latch & ~pend_clr & ~take) | pend_set | rise | capture;
            enable <= (enable | en_set) & ~en_clr;
            if (trig_wr) begin
                edge_mode <= trig_val;
            end
            if (take) begin
                active <= 1'b1;
            end else if (eoi_hit) begin
                active <= 1'b0;
            end
        end
    end

    assign pend_eff = edge_mode ? latch : (latch | line);
    assign cand     = enable & pend_eff & ~active;

    // R6
    nocapture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!LEGACY && en_set && !pend_set && !latch && !edge_mode) |=> !latch);

    // R7
    legacy_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (LEGACY && en_set && !edge_mode && line && !pend_clr && !take) |=> latch);

    // R5
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && line && !line_q) |=> latch);

    // R9
    act_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> active);

    // R11
    eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_hit && !take) |=> !active);

endmodule

// File: rtl/irqd_pick.sv
module irqd_pick #(
    parameter int NUM_SRC = 32,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] cand,
    output logic [NUM_SRC-1:0] onehot,
    output logic [IDX_W-1:0]   idx,
    output logic               valid
);

    always_comb begin
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                idx = IDX_W'(i);
            end
        end
        valid  = |cand;
        onehot = valid ? (NUM_SRC'(1) << idx) : '0;
    end

endmodule

// File: rtl/irqd_ack_fsm.sv
module irqd_ack_fsm
    import irqd_pkg::*;
#(
    parameter int ID_W  = 10,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_req,
    input  logic             pick_valid,
    input  logic [IDX_W-1:0] pick_idx,
    output logic             ack_fire,
    output logic             ack_done,
    output logic [ID_W-1:0]  ack_id
);

    localparam logic [ID_W-1:0] SPUR = ID_W'(SPURIOUS_ID);

    ack_state_e state, state_n;

    always_comb begin
        state_n = state;
        unique case (state)
            ACK_IDLE: if (ack_req) state_n = ACK_DONE;
            ACK_DONE: state_n = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ACK_IDLE;
        end else begin
            state <= state_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_id <= SPUR;
        end else if (ack_fire) begin
            ack_id <= pick_valid ? ID_W'(pick_idx) : SPUR;
        end
    end

    always_comb begin
        ack_fire = 1'b0;
        ack_done = 1'b0;
        unique case (state)
            ACK_IDLE: ack_fire = ack_req;
            ACK_DONE: ack_done = 1'b1;
        endcase
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_done |=> !ack_done);

endmodule

// File: rtl/irqd_top.sv
module irqd_top
    import irqd_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ID_W    = 10,
    parameter bit LEGACY  = 1'b0,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [2:0]         reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    input  logic [NUM_SRC-1:0] src_line,
    input  logic               ack_req,
    output logic               ack_done,
    output logic [ID_W-1:0]    ack_id,
    input  logic               eoi_valid,
    input  logic [ID_W-1:0]    eoi_id,
    output logic               irq_out
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(reg_addr);

    logic [NUM_SRC-1:0] en_vec, trig_vec, act_vec, pend_vec, cand_vec;
    logic [NUM_SRC-1:0] pick_onehot, take_vec;
    logic [IDX_W-1:0]   pick_idx;
    logic               pick_valid;
    logic               ack_fire;

    logic wr_set_en, wr_clr_en, wr_set_pd, wr_clr_pd, wr_trig;
    assign wr_set_en = reg_we && (sel == REG_SET_EN);
    assign wr_clr_en = reg_we && (sel == REG_CLR_EN);
    assign wr_set_pd = reg_we && (sel == REG_SET_PEND);
    assign wr_clr_pd = reg_we && (sel == REG_CLR_PEND);
    assign wr_trig   = reg_we && (sel == REG_TRIG);

    assign take_vec = pick_onehot & {NUM_SRC{ack_fire}};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        irqd_src_slice #(.LEGACY(LEGACY)) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .line      (src_line[i]),
            .en_set    (wr_set_en & reg_wdata[i]),
            .en_clr    (wr_clr_en & reg_wdata[i]),
            .pend_set  (wr_set_pd & reg_wdata[i]),
            .pend_clr  (wr_clr_pd & reg_wdata[i]),
            .trig_wr   (wr_trig),
            .trig_val  (reg_wdata[i]),
            .take      (take_vec[i]),
            .eoi_hit   (eoi_valid && (eoi_id == ID_W'(i))),
            .enable    (en_vec[i]),
            .edge_mode (trig_vec[i]),
            .active    (act_vec[i]),
            .pend_eff  (pend_vec[i]),
            .cand      (cand_vec[i])
        );
    end

    irqd_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .cand   (cand_vec),
        .onehot (pick_onehot),
        .idx    (pick_idx),
        .valid  (pick_valid)
    );

    irqd_ack_fsm #(.ID_W(ID_W), .IDX_W(IDX_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_req    (ack_req),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx),
        .ack_fire   (ack_fire),
        .ack_done   (ack_done),
        .ack_id     (ack_id)
    );

    always_comb begin
        unique case (sel)
            REG_SET_EN, REG_CLR_EN:     reg_rdata = en_vec;
            REG_SET_PEND, REG_CLR_PEND: reg_rdata = pend_vec;
            REG_TRIG:                   reg_rdata = trig_vec;
            REG_ACTIVE:                 reg_rdata = act_vec;
            default:                    reg_rdata = '0;
        endcase
    end

    assign irq_out = |cand_vec;

    // R9
    take_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take_vec));

    // R12
    irq_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> pick_valid);

endmodule

// File: tb/irqd_top_test.sv
`timescale 1ns/1ps
module irqd_top_test;

    localparam int N = 32;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_addr = 3'd0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] src_line = '0;
    logic         ack_req = 1'b0;
    logic         eoi_valid = 1'b0;
    logic [W-1:0] eoi_id = '0;
    logic [N-1:0] rdata, rdata_l;
    logic         done, done_l, irq, irq_l;
    logic [W-1:0] aid, aid_l;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    irqd_top #(.NUM_SRC(N), .ID_W(W), .LEGACY(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata), .src_line(src_line),
        .ack_req(ack_req), .ack_done(done), .ack_id(aid),
        .eoi_valid(eoi_valid), .eoi_id(eoi_id), .irq_out(irq));

    irqd_top #(.NUM_SRC(N), .ID_W(W), .LEGACY(1'b1)) uut_legacy (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_l), .src_line(src_line),
        .ack_req(ack_req), .ack_done(done_l), .ack_id(aid_l),
        .eoi_valid(eoi_valid), .eoi_id(eoi_id), .irq_out(irq_l));

    typedef struct packed {
        logic [31:0] lines;
        logic [2:0]  addr;
        logic [31:0] data;
        logic [31:0] exp_p;
        logic [31:0] exp_l;
        logic        exp_irq;
    } vec_t;

    // addr 7 = no write; bits 4..7 edge, 0..3 level
    localparam vec_t TBL [12] = '{
        '{32'h01, 3'd7, 32'h00, 32'h01, 32'h01, 1'b0},  // R3 level line
        '{32'h00, 3'd7, 32'h00, 32'h00, 32'h00, 1'b0},  // R3
        '{32'h10, 3'd7, 32'h00, 32'h10, 32'h10, 1'b0},  // R5 edge rise
        '{32'h00, 3'd7, 32'h00, 32'h10, 32'h10, 1'b0},  // R5 persists
        '{32'h00, 3'd3, 32'h10, 32'h00, 32'h00, 1'b0},  // R4
        '{32'h02, 3'd2, 32'h04, 32'h06, 32'h06, 1'b0},  // R3 sw set
        '{32'h00, 3'd7, 32'h00, 32'h04, 32'h04, 1'b0},  // R3 latch holds
        '{32'h08, 3'd3, 32'h0C, 32'h08, 32'h08, 1'b0},  // R4 line keeps
        '{32'h08, 3'd0, 32'h08, 32'h08, 32'h08, 1'b1},  // R6/R7 enable
        '{32'h00, 3'd7, 32'h00, 32'h00, 32'h08, 1'b0},  // R6 vs R7
        '{32'h20, 3'd7, 32'h00, 32'h20, 32'h28, 1'b0},  // R5
        '{32'h20, 3'd3, 32'h20, 32'h00, 32'h08, 1'b0}   // R5 held high
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
        reg_addr = a;
        #1;
        d = rdata;
    endtask

    task automatic ack(input string req, input int exp_id);
        @(negedge clk);
        ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
        #1;
        chk({req, " ack_done"}, 32'(done), 32'd1);
        chk({req, " ack_id"}, 32'(aid), 32'(exp_id));
        @(negedge clk);
    endtask

    task automatic eoi(input int id);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_id = W'(id);
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 irq_out", 32'(irq), 0);
        chk("R1 ack_done", 32'(done), 0);
        rd(3'd0, v); chk("R1 enable", v, 0);
        rd(3'd2, v); chk("R1 pending", v, 0);
        rd(3'd4, v); chk("R1 trig", v, 0);
        rd(3'd5, v); chk("R1 active", v, 0);

        wr(3'd4, 32'hF0);
        rd(3'd4, v); chk("R2 trig rw", v, 32'hF0);

        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            src_line = TBL[k].lines;
            if (TBL[k].addr != 3'd7) begin
                reg_we = 1'b1; reg_addr = TBL[k].addr; reg_wdata = TBL[k].data;
            end
            @(negedge clk);
            reg_we = 1'b0; reg_wdata = '0; reg_addr = 3'd2;
            #1;
            chk($sformatf("R3/R4/R5/R6 vec%0d pend", k), rdata, TBL[k].exp_p);
            chk($sformatf("R7 vec%0d legacy pend", k), rdata_l, TBL[k].exp_l);
            chk($sformatf("R12 vec%0d irq", k), 32'(irq), 32'(TBL[k].exp_irq));
        end

        // R8 enable set/clear
        wr(3'd0, 32'hF0);
        rd(3'd0, v); chk("R8 set-enable", v, 32'hF8);
        wr(3'd1, 32'h08);
        rd(3'd1, v); chk("R8 clear-enable", v, 32'hF0);
        rd(3'd6, v); chk("R2 unused select", v, 0);

        // R9 ordering, R10 spurious, R11 mismatch
        @(negedge clk); src_line = '0;
        wr(3'd2, 32'h60);
        #1; chk("R12 irq pending", 32'(irq), 1);
        ack("R9 lowest first", 5);
        rd(3'd2, v); chk("R9 latch cleared", v, 32'h40);
        rd(3'd5, v); chk("R9 active set", v, 32'h20);
        chk("R12 irq still", 32'(irq), 1);
        ack("R9 next", 6);
        chk("R12 irq none", 32'(irq), 0);
        ack("R10 spurious", 1023);
        rd(3'd5, v); chk("R10 no state change", v, 32'h60);
        eoi(9);
        rd(3'd5, v); chk("R11 mismatched eoi", v, 32'h60);
        eoi(6);
        rd(3'd5, v); chk("R11 eoi 6", v, 32'h20);
        eoi(5);
        rd(3'd5, v); chk("R11 eoi 5", v, 32'h00);

        // R11 level line still high at eoi
        wr(3'd1, '1);
        wr(3'd0, 32'h01);
        @(negedge clk); src_line = 32'h01;
        #1; chk("R12 level request", 32'(irq), 1);
        ack("R11 level ack", 0);
        chk("R12 active masks", 32'(irq), 0);
        rd(3'd2, v); chk("R3 line keeps pending", v, 32'h01);
        eoi(0);
        #1; chk("R11 re-pend after eoi", 32'(irq), 1);
        @(negedge clk); src_line = '0;
        #1; chk("R3 line low", 32'(irq), 0);

        // R3 acknowledge clears level latch
        wr(3'd2, 32'h01);
        #1; chk("R3 sw pend irq", 32'(irq), 1);
        ack("R3 ack sw level", 0);
        rd(3'd2, v); chk("R3 latch cleared by ack", v, 0);
        eoi(0);
        #1; chk("R12 idle", 32'(irq), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule